// File: doc/BRIEF.md
# Inclusive Last-Level Cache Slice Directory Controller

This block is the control logic for one slice of an inclusive last-level cache. Each slice entry stores a line address tag, the line data, a line state and a presence vector that has one bit per core. Cores send read requests and ownership requests to the slice. The slice answers every request with a data response that goes to the requesting core.

A line in the modified state is owned by the single core whose presence bit is set. While a line is in that state, the slice treats its own copy as stale. Before it answers another core, the slice snoops the owner, takes the dirty data, and writes that data into its own copy. For an ownership request, the slice first invalidates every other holder of the line, one at a time. A lookup that misses fetches the line from a simple memory port and installs it. Placement is direct-mapped. Nothing is written back on eviction and nothing is back-invalidated. The slice handles one transaction at a time, so a request to a line that has a snoop in flight waits until that transaction has been answered.

Top module: `llc_slice_dir`

## Requirements
- R1: After reset the request port is ready, no response, snoop or memory request is valid, and every slice entry is invalid, so the first access to any line misses.
- R2: A request that misses issues exactly one memory request for its line address. The returned memory data is sent to the requester, and no snoop is issued.
- R3: A read miss installs the line in the clean state with only the requester's presence bit set. The line index is the low INDEX_W bits of the line address.
- R4: A read that hits a clean line is answered from slice data with no snoop and no memory request, and the requester's presence bit is added.
- R5: A read (reqKind 0) that hits a line modified by another core sends one downgrade snoop (snpKind 0) to the owner and never returns the stale slice copy. The reply carries the data that the owner returned.
- R6: After that downgrade, the slice copy holds the dirty data and the line is clean, with the presence bits of both the previous owner and the requester set.
- R7: An ownership request (reqKind 1) that hits a clean line sends an invalidate snoop (snpKind 1) to each other present core, one at a time in ascending core index. It then answers with the slice data, and data carried by those acknowledgements is ignored.
- R8: An ownership request that hits a line modified by another core invalidates that owner, replies with the owner's dirty data, and leaves the requester as the sole modified owner.
- R9: An ownership request that misses installs the fetched line as modified, owned by the requester alone.
- R10: A request from the core that already owns the line modified is answered from slice data with no snoop, and the directory entry does not change.
- R11: Only one transaction is open at a time. Once a request is accepted, the request port stays not ready until the cycle after the reply, and a request held during that time is accepted only afterwards.
- R12: A miss on an index that holds a different tag replaces that entry, so a later access to the replaced line misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core request valid |
| reqReady | output | 1 | Slice can accept a request |
| reqCore | input | CORE_W | Requesting core index |
| reqKind | input | 1 | 0 read, 1 ownership |
| reqAddr | input | LINE_ADDR_W | Line address |
| snpValid | output | 1 | Snoop to a core, one-cycle pulse |
| snpCore | output | CORE_W | Snooped core |
| snpKind | output | 1 | 0 downgrade, 1 invalidate |
| snpAddr | output | LINE_ADDR_W | Snooped line address |
| snpRspValid | input | 1 | Snoop answer valid |
| snpRspData | input | DATA_W | Dirty data from the snooped core |
| rspValid | output | 1 | Data response valid, one-cycle pulse |
| rspCore | output | CORE_W | Core the response is for |
| rspData | output | DATA_W | Line data |
| memReqValid | output | 1 | Memory fetch request, one-cycle pulse |
| memReqAddr | output | LINE_ADDR_W | Line address to fetch |
| memRspValid | input | 1 | Memory data valid |
| memRspData | input | DATA_W | Fetched line data |

## Verification
A sweep covers every core and every index. In each step one core read-misses a line and the next core requests ownership of it. The ownership request must produce exactly one invalidate to the first core, which tells presence tracking on a miss apart from any broadcast. A directed chain on one line then moves through clean sharing, ownership, downgrade, re-ownership and an owner re-read. The snoop sequence seen at each step exposes the state and presence vector left by the step before, and the returned data shows whether the stale slice copy or the snooped copy was used. Two further patterns cover the remaining cases. Conflicting tags on one index show replacement. A request held during an open snoop shows that the second requester is served later, from the updated copy.

// File: rtl/llc_slice_dir_pkg.sv
package llc_slice_dir_pkg;

  typedef enum logic [1:0] {
    LINE_INV   = 2'd0,
    LINE_CLEAN = 2'd1,
    LINE_MOD   = 2'd2
  } lineState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capReq;     // latch the accepted request
    logic decide;     // load line buffer and snoop mask from the indexed entry
    logic fillLine;   // install memory data
    logic snpAccept;  // consume one snoop answer
    logic dirUpdate;  // final directory write on a hit
  } ctlStrobe_t;

endpackage

// File: rtl/slice_dir_datapath.sv
module slice_dir_datapath
  import llc_slice_dir_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int LINE_ADDR_W = 8,
  parameter int INDEX_W     = 2,
  parameter int DATA_W      = 32,
  localparam int CORE_W     = $clog2(NUM_CORES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobe_t             strobe,
  input  logic [CORE_W-1:0]      reqCore,
  input  logic                   reqKind,
  input  logic [LINE_ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]      memRspData,
  input  logic [DATA_W-1:0]      snpRspData,
  output logic                   hit,
  output logic                   pendEmpty,
  output logic [CORE_W-1:0]      curCore,
  output logic                   curKind,
  output logic [LINE_ADDR_W-1:0] curAddr,
  output logic [DATA_W-1:0]      lineBuf,
  output logic [CORE_W-1:0]      snpTarget
);
  localparam int TAG_W = LINE_ADDR_W - INDEX_W;
  localparam int SETS  = 1 << INDEX_W;

  lineState_t           stateArr [SETS];
  logic [TAG_W-1:0]     tagArr   [SETS];
  logic [NUM_CORES-1:0] presArr  [SETS];
  logic [DATA_W-1:0]    dataArr  [SETS];

  logic [NUM_CORES-1:0] pending;
  logic                 wasMod;
  logic                 selfOwn;

  logic [INDEX_W-1:0]   curIdx;
  logic [TAG_W-1:0]     curTag;
  logic [NUM_CORES-1:0] reqBit;
  logic [NUM_CORES-1:0] entPres;
  lineState_t           entState;
  logic                 modOther;
  logic [NUM_CORES-1:0] pendNext;

  assign curIdx   = curAddr[INDEX_W-1:0];
  assign curTag   = curAddr[LINE_ADDR_W-1:INDEX_W];
  assign entState = stateArr[curIdx];
  assign entPres  = presArr[curIdx];
  assign hit      = (entState != LINE_INV) && (tagArr[curIdx] == curTag);
  assign pendEmpty = (pending == '0);

  always_comb begin
    reqBit = '0;
    reqBit[curCore] = 1'b1;
  end

  // Cores to snoop: every other holder for ownership, the owner for a read
  assign modOther = (entState == LINE_MOD) && ((entPres & ~reqBit) != '0);
  assign pendNext = curKind ? (entPres & ~reqBit)
                            : (modOther ? entPres : '0);

  // Lowest pending core is snooped first
  always_comb begin
    logic found;
    found = 1'b0;
    snpTarget = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (pending[i] && !found) begin
        snpTarget = CORE_W'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCore <= '0;
      curKind <= 1'b0;
      curAddr <= '0;
      lineBuf <= '0;
      pending <= '0;
      wasMod  <= 1'b0;
      selfOwn <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        stateArr[s] <= LINE_INV;
        tagArr[s]   <= '0;
        presArr[s]  <= '0;
        dataArr[s]  <= '0;
      end
    end else begin
      if (strobe.capReq) begin
        curCore <= reqCore;
        curKind <= reqKind;
        curAddr <= reqAddr;
      end
      if (strobe.decide) begin
        lineBuf <= dataArr[curIdx];
        pending <= hit ? pendNext : '0;
        wasMod  <= (entState == LINE_MOD);
        selfOwn <= (entState == LINE_MOD) && (entPres == reqBit);
      end
      if (strobe.fillLine) begin
        lineBuf          <= memRspData;
        dataArr[curIdx]  <= memRspData;
        tagArr[curIdx]   <= curTag;
        stateArr[curIdx] <= curKind ? LINE_MOD : LINE_CLEAN;
        presArr[curIdx]  <= reqBit;
      end
      if (strobe.snpAccept) begin
        pending <= pending & (pending - 1'b1);
        if (wasMod) begin
          lineBuf         <= snpRspData;
          dataArr[curIdx] <= snpRspData;
        end
      end
      if (strobe.dirUpdate && !selfOwn) begin
        if (curKind) begin
          stateArr[curIdx] <= LINE_MOD;
          presArr[curIdx]  <= reqBit;
        end else begin
          stateArr[curIdx] <= LINE_CLEAN;
          presArr[curIdx]  <= entPres | reqBit;
        end
      end
    end
  end

  // A hit on a line owned elsewhere must leave a snoop to do
  assert_stale_guard_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decide && hit && modOther) |=> !pendEmpty);

  // Fill leaves the indexed entry in the state the request kind asks for
  assert_fill_state_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillLine |=> (stateArr[curIdx] == (curKind ? LINE_MOD : LINE_CLEAN)));

  for (genvar g = 0; g < SETS; g++) begin : g_entryChecks
    // Inclusion: a valid entry is held by at least one core (R3)
    assert_valid_held_R3: assert property (@(posedge clk) disable iff (!rstN)
      (stateArr[g] != LINE_INV) |-> (presArr[g] != '0));
    // A modified entry names exactly one owner (R8)
    assert_mod_one_owner_R8: assert property (@(posedge clk) disable iff (!rstN)
      (stateArr[g] == LINE_MOD) |-> ($countones(presArr[g]) == 1));
  end

endmodule

// File: rtl/slice_dir_ctrl.sv
module slice_dir_ctrl
  import llc_slice_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       hit,
  input  logic       pendEmpty,
  input  logic       memRspValid,
  input  logic       snpRspValid,
  output logic       reqReady,
  output logic       memReqValid,
  output logic       snpValid,
  output logic       rspValid,
  output ctlStrobe_t strobe
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_MEMREQ, ST_MEMWAIT,
    ST_NEXT, ST_SNP, ST_SNPWAIT, ST_REPLY
  } ctlState_t;

  ctlState_t state, stateNext;

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    snpValid    = 1'b0;
    rspValid    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capReq = 1'b1;
          stateNext = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        strobe.decide = 1'b1;
        stateNext = hit ? ST_NEXT : ST_MEMREQ;
      end
      ST_MEMREQ: begin
        memReqValid = 1'b1;
        stateNext = ST_MEMWAIT;
      end
      ST_MEMWAIT: begin
        if (memRspValid) begin
          strobe.fillLine = 1'b1;
          stateNext = ST_REPLY;
        end
      end
      ST_NEXT: begin
        if (!pendEmpty) begin
          stateNext = ST_SNP;
        end else begin
          strobe.dirUpdate = 1'b1;
          stateNext = ST_REPLY;
        end
      end
      ST_SNP: begin
        snpValid = 1'b1;
        stateNext = ST_SNPWAIT;
      end
      ST_SNPWAIT: begin
        if (snpRspValid) begin
          strobe.snpAccept = 1'b1;
          stateNext = ST_NEXT;
        end
      end
      ST_REPLY: begin
        rspValid = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assert_accept_blocks_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_reply_frees_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady);

endmodule

// File: rtl/llc_slice_dir.sv
module llc_slice_dir
  import llc_slice_dir_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int LINE_ADDR_W = 8,
  parameter int INDEX_W     = 2,
  parameter int DATA_W      = 32,
  localparam int CORE_W     = $clog2(NUM_CORES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [CORE_W-1:0]      reqCore,
  input  logic                   reqKind,
  input  logic [LINE_ADDR_W-1:0] reqAddr,
  output logic                   snpValid,
  output logic [CORE_W-1:0]      snpCore,
  output logic                   snpKind,
  output logic [LINE_ADDR_W-1:0] snpAddr,
  input  logic                   snpRspValid,
  input  logic [DATA_W-1:0]      snpRspData,
  output logic                   rspValid,
  output logic [CORE_W-1:0]      rspCore,
  output logic [DATA_W-1:0]      rspData,
  output logic                   memReqValid,
  output logic [LINE_ADDR_W-1:0] memReqAddr,
  input  logic                   memRspValid,
  input  logic [DATA_W-1:0]      memRspData
);
  ctlStrobe_t              strobe;
  logic                    hit;
  logic                    pendEmpty;
  logic [CORE_W-1:0]       curCore;
  logic                    curKind;
  logic [LINE_ADDR_W-1:0]  curAddr;
  logic [DATA_W-1:0]       lineBuf;
  logic [CORE_W-1:0]       snpTarget;

  slice_dir_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .hit         (hit),
    .pendEmpty   (pendEmpty),
    .memRspValid (memRspValid),
    .snpRspValid (snpRspValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .snpValid    (snpValid),
    .rspValid    (rspValid),
    .strobe      (strobe)
  );

  slice_dir_datapath #(
    .NUM_CORES   (NUM_CORES),
    .LINE_ADDR_W (LINE_ADDR_W),
    .INDEX_W     (INDEX_W),
    .DATA_W      (DATA_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqCore    (reqCore),
    .reqKind    (reqKind),
    .reqAddr    (reqAddr),
    .memRspData (memRspData),
    .snpRspData (snpRspData),
    .hit        (hit),
    .pendEmpty  (pendEmpty),
    .curCore    (curCore),
    .curKind    (curKind),
    .curAddr    (curAddr),
    .lineBuf    (lineBuf),
    .snpTarget  (snpTarget)
  );

  assign snpCore    = snpTarget;
  assign snpKind    = curKind;
  assign snpAddr    = curAddr;
  assign rspCore    = curCore;
  assign rspData    = lineBuf;
  assign memReqAddr = curAddr;

  // The requester is never snooped for its own request
  assert_snoop_other_core_R7: assert property (@(posedge clk) disable iff (!rstN)
    snpValid |-> (snpCore != rspCore));

endmodule

// File: tb/llc_slice_dir_bench.sv
module llc_slice_dir_bench;
  localparam int NC = 4;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [1:0]    reqCore = '0;
  logic          reqKind = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          snpValid;
  logic [1:0]    snpCore;
  logic          snpKind;
  logic [AW-1:0] snpAddr;
  logic          snpRspValid = 1'b0;
  logic [DW-1:0] snpRspData = '0;
  logic          rspValid;
  logic [1:0]    rspCore;
  logic [DW-1:0] rspData;
  logic          memReqValid;
  logic [AW-1:0] memReqAddr;
  logic          memRspValid = 1'b0;
  logic [DW-1:0] memRspData = '0;

  llc_slice_dir #(.NUM_CORES(NC), .LINE_ADDR_W(AW), .INDEX_W(2), .DATA_W(DW))
  u_llc_slice_dir (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqCore(reqCore),
    .reqKind(reqKind), .reqAddr(reqAddr),
    .snpValid(snpValid), .snpCore(snpCore), .snpKind(snpKind), .snpAddr(snpAddr),
    .snpRspValid(snpRspValid), .snpRspData(snpRspData),
    .rspValid(rspValid), .rspCore(rspCore), .rspData(rspData),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  int nChecks = 0;
  int nFail = 0;

  function automatic logic [DW-1:0] memData(logic [AW-1:0] a);
    return 32'h5A00_0000 | {16'h0, a, ~a};
  endfunction

  function automatic logic [DW-1:0] dirtyData(logic [AW-1:0] a, logic [1:0] c);
    return 32'hD000_0000 | (32'(c) << 16) | 32'(a);
  endfunction

  task automatic checkEq(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory and snoop responders, driven away from the active edge
  int memCnt = 0;
  logic [AW-1:0] memLastAddr = '0;
  int memTimer = 0;
  int snpN = 0;
  logic [1:0]    snpLogCore [8];
  logic          snpLogKind [8];
  logic [AW-1:0] snpLogAddr [8];
  int snpTimer = 0;
  logic [1:0]    snpPendCore = '0;
  logic [AW-1:0] snpPendAddr = '0;

  always @(negedge clk) begin
    memRspValid = 1'b0;
    if (memTimer > 0) begin
      memTimer--;
      if (memTimer == 0) begin
        memRspValid = 1'b1;
        memRspData  = memData(memLastAddr);
      end
    end
    if (rstN && memReqValid) begin
      memCnt++;
      memLastAddr = memReqAddr;
      memTimer = 3;
    end
  end

  always @(negedge clk) begin
    snpRspValid = 1'b0;
    if (snpTimer > 0) begin
      snpTimer--;
      if (snpTimer == 0) begin
        snpRspValid = 1'b1;
        snpRspData  = dirtyData(snpPendAddr, snpPendCore);
      end
    end
    if (rstN && snpValid) begin
      if (snpN < 8) begin
        snpLogCore[snpN] = snpCore;
        snpLogKind[snpN] = snpKind;
        snpLogAddr[snpN] = snpAddr;
      end
      snpN++;
      snpPendCore = snpCore;
      snpPendAddr = snpAddr;
      snpTimer = 2;
    end
  end

  logic [DW-1:0] gotData;
  logic [1:0]    gotCore;

  task automatic clearLogs();
    memCnt = 0;
    snpN = 0;
  endtask

  task automatic issueReq(logic [1:0] c, logic k, logic [AW-1:0] a);
    @(negedge clk);
    clearLogs();
    reqValid = 1'b1; reqCore = c; reqKind = k; reqAddr = a;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitRsp(string req);
    int guard = 0;
    bit busyOk = 1'b1;
    while (!rspValid && guard < 200) begin
      if (reqReady) busyOk = 1'b0;
      @(negedge clk);
      guard++;
    end
    checkEq(req, "reply seen", 32'(rspValid), 32'd1);
    gotData = rspData;
    gotCore = rspCore;
    checkEq("R11", "port busy until reply", 32'(busyOk), 32'd1);
    @(negedge clk);
    checkEq("R11", "ready after reply", 32'(reqReady), 32'd1);
  endtask

  // expSeq: one nibble per snoop, low nibble first: bit2 kind, bits1:0 core
  task automatic checkTxn(string req, logic [1:0] c, logic [AW-1:0] a,
                          logic [DW-1:0] expData, int expMem, int expSnp, int expSeq);
    checkEq(req, "rspData", gotData, expData);
    checkEq(req, "rspCore", 32'(gotCore), 32'(c));
    checkEq(req, "memory fetches", 32'(memCnt), 32'(expMem));
    if (expMem > 0) checkEq(req, "memory address", 32'(memLastAddr), 32'(a));
    checkEq(req, "snoop count", 32'(snpN), 32'(expSnp));
    for (int i = 0; i < expSnp && i < snpN && i < 8; i++) begin
      checkEq(req, "snoop core", 32'(snpLogCore[i]), 32'((expSeq >> (4*i)) & 3));
      checkEq(req, "snoop kind", 32'(snpLogKind[i]), 32'((expSeq >> (4*i + 2)) & 1));
      checkEq(req, "snoop addr", 32'(snpLogAddr[i]), 32'(a));
    end
  endtask

  task automatic doTxn(string req, logic [1:0] c, logic k, logic [AW-1:0] a,
                       logic [DW-1:0] expData, int expMem, int expSnp, int expSeq);
    issueReq(c, k, a);
    waitRsp(req);
    checkTxn(req, c, a, expData, expMem, expSnp, expSeq);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    checkEq("R1", "reqReady", 32'(reqReady), 32'd1);
    checkEq("R1", "rspValid", 32'(rspValid), 32'd0);
    checkEq("R1", "snpValid", 32'(snpValid), 32'd0);
    checkEq("R1", "memReqValid", 32'(memReqValid), 32'd0);

    // R3 sweep: every core and index; read miss then ownership by the next core
    for (int c = 0; c < NC; c++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a;
        logic [1:0] nxt;
        a = AW'(((c + 16) << 2) | s);
        nxt = 2'((c + 1) % NC);
        doTxn("R2", 2'(c), 1'b0, a, memData(a), 1, 0, 0);
        doTxn("R3", nxt, 1'b1, a, memData(a), 0, 1, 4 | c);
      end
    end

    // Directed chain on one line (index 0)
    doTxn("R1", 2'd0, 1'b0, 8'h14, memData(8'h14), 1, 0, 0);
    doTxn("R4", 2'd1, 1'b0, 8'h14, memData(8'h14), 0, 0, 0);
    doTxn("R7", 2'd2, 1'b1, 8'h14, memData(8'h14), 0, 2, 32'h54);
    doTxn("R5", 2'd3, 1'b0, 8'h14, dirtyData(8'h14, 2'd2), 0, 1, 32'h2);
    doTxn("R6", 2'd1, 1'b0, 8'h14, dirtyData(8'h14, 2'd2), 0, 0, 0);
    doTxn("R6", 2'd0, 1'b1, 8'h14, dirtyData(8'h14, 2'd2), 0, 3, 32'h765);
    doTxn("R8", 2'd1, 1'b1, 8'h14, dirtyData(8'h14, 2'd0), 0, 1, 32'h4);
    doTxn("R10", 2'd1, 1'b0, 8'h14, dirtyData(8'h14, 2'd0), 0, 0, 0);
    doTxn("R10", 2'd2, 1'b0, 8'h14, dirtyData(8'h14, 2'd1), 0, 1, 32'h1);

    // Ownership miss and replacement on index 3
    doTxn("R9", 2'd3, 1'b1, 8'h27, memData(8'h27), 1, 0, 0);
    doTxn("R9", 2'd0, 1'b0, 8'h27, dirtyData(8'h27, 2'd3), 0, 1, 32'h3);
    doTxn("R12", 2'd2, 1'b0, 8'h33, memData(8'h33), 1, 0, 0);
    doTxn("R12", 2'd1, 1'b0, 8'h27, memData(8'h27), 1, 0, 0);

    // R11: a request held while a snoop is open is served afterwards
    doTxn("R9", 2'd3, 1'b1, 8'h05, memData(8'h05), 1, 0, 0);
    issueReq(2'd0, 1'b0, 8'h05);
    @(negedge clk);
    reqValid = 1'b1; reqCore = 2'd2; reqKind = 1'b0; reqAddr = 8'h05;
    waitRsp("R11");
    checkTxn("R11", 2'd0, 8'h05, dirtyData(8'h05, 2'd3), 0, 1, 32'h3);
    clearLogs();
    @(negedge clk);
    reqValid = 1'b0;
    waitRsp("R11");
    checkTxn("R11", 2'd2, 8'h05, dirtyData(8'h05, 2'd3), 0, 0, 0);

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule